// File: doc/BRIEF.md
# SPI Buffer-Status Interrupt Logic

This block keeps the two buffer-status bits of a serial peripheral port and turns them into interrupts. The shift engine sends two strobes: one when the pending transmit byte has moved into the shift register, and one when a received byte has landed in the receive buffer. Each strobe sets its own status bit. Each cause has its own enable bit in a control register. When a cause is enabled, the strobe also drives a one-cycle pulse on a single shared interrupt line. Software reads the status register to find out which cause fired.

The shared line feeds one interrupt-controller channel. The channel holds a sticky flag, a channel enable and a 3-bit priority level. The flag latches every pulse, whether or not the channel enable is set. The request to the core is the flag gated by the channel enable, and the level is presented with it.

The CPU side is a simple register port: a 3-bit address with write and read strobes. Address 0 is the status register, which is read-only and driven out directly. Address 1 is control. Address 2 is the transmit-data write. Address 3 is the receive-data read. Address 4 is the flag clear. Address 5 is the channel enable. Address 6 is the level.

Top module: `spi_irq_top`

## Requirements
- R1: After a synchronous active-low reset, `status_o` = 0x01, `ctrl_o` = 0x00, `irq_pulse_o` = 0, `flag_o` = 0, `core_req_o` = 0 and `core_lvl_o` = 0.
- R2: Bit 0 of `status_o` (transmit empty) becomes 1 on the clock edge that samples `tx_load_i`. A write to address 2 clears it. If both happen in the same cycle, the strobe wins.
- R3: Bit 1 of `status_o` (receive full) becomes 1 on the clock edge that samples `rx_load_i`. A read (`rd_en_i`) of address 3 clears it. If both happen in the same cycle, the strobe wins.
- R4: A write to address 1 loads `wr_data_i` bit 4 into the transmit-empty interrupt enable and bit 5 into the receive-full interrupt enable. These appear at the same positions of `ctrl_o`. All other bits of `ctrl_o` read 0.
- R5: `irq_pulse_o` is 1 for exactly the cycle in which a status bit is newly set by a strobe, and only if that cause's enable was 1 when the strobe was sampled. With both enables at 0, no pulse is emitted.
- R6: When both strobes come in the same cycle and both causes are enabled, one single-cycle pulse is emitted and both status bits are set.
- R7: `flag_o` becomes 1 on the edge after a pulse, regardless of the channel enable.
- R8: A write to address 4 with `wr_data_i` bit 0 = 1 clears `flag_o`. If a pulse is present in the same cycle, the flag stays 1.
- R9: A write to address 5 loads the channel enable from `wr_data_i` bit 0. `core_req_o` equals `flag_o` AND the channel enable.
- R10: A write to address 6 loads `core_lvl_o` from `wr_data_i[2:0]`. The level holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_load_i | input | 1 | Strobe: transmit byte moved to shift register |
| rx_load_i | input | 1 | Strobe: received byte loaded into receive buffer |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Write data |
| status_o | output | 8 | Status register (bit 0 transmit empty, bit 1 receive full) |
| ctrl_o | output | 8 | Control register (bit 4, bit 5 interrupt enables) |
| irq_pulse_o | output | 1 | Shared interrupt pulse to the controller channel |
| flag_o | output | 1 | Controller channel sticky flag |
| core_req_o | output | 1 | Interrupt request to the core |
| core_lvl_o | output | 3 | Interrupt level presented with the request |

## Verification
The assertions check, on every cycle, the properties that tie signals together in time. A strobe always leaves its status bit set on the next edge. A pulse always leaves the flag set. A pulse never appears while both enables are off. The level never moves without a level write. The bench scenarios are needed for the rest. These cover the reset values, the priority of a strobe over a same-cycle clear, the fact that a disabled channel still latches its flag, the single pulse for two simultaneous causes, and the flag clear racing a new pulse.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int LVL_W   = 3;
    localparam int TBE_BIT = 0;
    localparam int RBF_BIT = 1;
    localparam int TIE_BIT = 4;
    localparam int RIE_BIT = 5;

    typedef enum logic [ADDR_W-1:0] {
        REG_STAT = 3'd0,
        REG_CTRL = 3'd1,
        REG_TXD  = 3'd2,
        REG_RXD  = 3'd3,
        REG_FCLR = 3'd4,
        REG_CEN  = 3'd5,
        REG_LVL  = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_txd;
        logic rd_rxd;
        logic wr_fclr;
        logic wr_cen;
        logic wr_lvl;
    } access_t;
endpackage

// File: rtl/spi_irq_decode.sv
module spi_irq_decode
    import spi_irq_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    output access_t       acc
);
    always_comb begin
        acc         = '0;
        acc.wr_ctrl = wr_en && (addr == REG_CTRL);
        acc.wr_txd  = wr_en && (addr == REG_TXD);
        acc.rd_rxd  = rd_en && (addr == REG_RXD);
        acc.wr_fclr = wr_en && (addr == REG_FCLR);
        acc.wr_cen  = wr_en && (addr == REG_CEN);
        acc.wr_lvl  = wr_en && (addr == REG_LVL);
    end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
    import spi_irq_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_load,
    input  logic          rx_load,
    input  access_t       acc,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] status,
    output logic [DW-1:0] ctrl,
    output logic          pulse
);
    typedef struct packed {
        logic tbe;
        logic rbf;
        logic tie;
        logic rie;
        logic pulse;
    } st_t;

    localparam st_t RST_VAL = '{tbe: 1'b1, rbf: 1'b0, tie: 1'b0, rie: 1'b0, pulse: 1'b0};

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // transmit empty: strobe has priority over the data write
        if (tx_load)         s_d.tbe = 1'b1;
        else if (acc.wr_txd) s_d.tbe = 1'b0;
        // receive full: strobe has priority over the data read
        if (rx_load)         s_d.rbf = 1'b1;
        else if (acc.rd_rxd) s_d.rbf = 1'b0;
        if (acc.wr_ctrl) begin
            s_d.tie = wr_data[TIE_BIT];
            s_d.rie = wr_data[RIE_BIT];
        end
        // one merged pulse for any enabled cause
        s_d.pulse = (tx_load && s_q.tie) || (rx_load && s_q.rie);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= RST_VAL;
        else        s_q <= s_d;
    end

    always_comb begin
        status          = '0;
        status[TBE_BIT] = s_q.tbe;
        status[RBF_BIT] = s_q.rbf;
        ctrl            = '0;
        ctrl[TIE_BIT]   = s_q.tie;
        ctrl[RIE_BIT]   = s_q.rie;
        pulse           = s_q.pulse;
    end
endmodule

// File: rtl/spi_irq_chan.sv
module spi_irq_chan
    import spi_irq_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int LW = LVL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pulse,
    input  access_t       acc,
    input  logic [DW-1:0] wr_data,
    output logic          flag,
    output logic          req,
    output logic [LW-1:0] lvl
);
    typedef struct packed {
        logic          flag;
        logic          en;
        logic [LW-1:0] lvl;
    } ch_t;

    ch_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (pulse)                         c_d.flag = 1'b1;
        else if (acc.wr_fclr && wr_data[0]) c_d.flag = 1'b0;
        if (acc.wr_cen) c_d.en  = wr_data[0];
        if (acc.wr_lvl) c_d.lvl = wr_data[LW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign flag = c_q.flag;
    assign req  = c_q.flag && c_q.en;
    assign lvl  = c_q.lvl;
endmodule

// File: rtl/spi_irq_top.sv
module spi_irq_top
    import spi_irq_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int LW = LVL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_load_i,
    input  logic          rx_load_i,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [DW-1:0] status_o,
    output logic [DW-1:0] ctrl_o,
    output logic          irq_pulse_o,
    output logic          flag_o,
    output logic          core_req_o,
    output logic [LW-1:0] core_lvl_o
);
    access_t acc;

    spi_irq_decode #(.AW(AW)) u_dec (
        .wr_en (wr_en_i),
        .rd_en (rd_en_i),
        .addr  (addr_i),
        .acc   (acc)
    );

    spi_irq_status #(.DW(DW)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_load (tx_load_i),
        .rx_load (rx_load_i),
        .acc     (acc),
        .wr_data (wr_data_i),
        .status  (status_o),
        .ctrl    (ctrl_o),
        .pulse   (irq_pulse_o)
    );

    spi_irq_chan #(.DW(DW), .LW(LW)) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse   (irq_pulse_o),
        .acc     (acc),
        .wr_data (wr_data_i),
        .flag    (flag_o),
        .req     (core_req_o),
        .lvl     (core_lvl_o)
    );
endmodule

// File: rtl/spi_irq_check.sv
module spi_irq_check
    import spi_irq_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int LW = LVL_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_load_i,
    input logic          rx_load_i,
    input logic          wr_en_i,
    input logic [AW-1:0] addr_i,
    input logic [DW-1:0] status_o,
    input logic [DW-1:0] ctrl_o,
    input logic          irq_pulse_o,
    input logic          flag_o,
    input logic [LW-1:0] core_lvl_o
);
    AST_TX_SETS_TBE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_i |=> status_o[TBE_BIT]); // R2
    AST_RX_SETS_RBF: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load_i |=> status_o[RBF_BIT]); // R3
    AST_NO_PULSE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o[TIE_BIT] == 1'b0 && ctrl_o[RIE_BIT] == 1'b0) |=> !irq_pulse_o); // R5
    AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse_o |-> (status_o[TBE_BIT] || status_o[RBF_BIT])); // R5
    AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse_o |=> flag_o); // R7
    AST_LVL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && addr_i == REG_LVL) |=> $stable(core_lvl_o)); // R10
endmodule

bind spi_irq_top spi_irq_check #(.DW(DW), .AW(AW), .LW(LW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_load_i   (tx_load_i),
    .rx_load_i   (rx_load_i),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .status_o    (status_o),
    .ctrl_o      (ctrl_o),
    .irq_pulse_o (irq_pulse_o),
    .flag_o      (flag_o),
    .core_lvl_o  (core_lvl_o)
);

// File: tb/tb_spi_irq_top.sv
module tb_spi_irq_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_load_i = 1'b0, rx_load_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
    logic [2:0] addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [7:0] status_o, ctrl_o;
    logic       irq_pulse_o, flag_o, core_req_o;
    logic [2:0] core_lvl_o;

    spi_irq_top dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [21:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference state
    logic m_tbe = 1, m_rbf = 0, m_tie = 0, m_rie = 0, m_pulse = 0, m_flag = 0, m_en = 0;
    logic [2:0] m_lvl = 0;

    task automatic step(input logic tx, input logic rx, input logic we, input logic re,
                        input logic [2:0] a, input logic [7:0] d, input string tag);
        logic n_pulse, n_flag;
        item_t it;
        @(negedge clk);
        tx_load_i = tx; rx_load_i = rx; wr_en_i = we; rd_en_i = re;
        addr_i = a; wr_data_i = d;
        n_pulse = (tx & m_tie) | (rx & m_rie);
        n_flag  = m_pulse ? 1'b1 : ((we && a == 3'd4 && d[0]) ? 1'b0 : m_flag);
        m_tbe   = tx ? 1'b1 : ((we && a == 3'd2) ? 1'b0 : m_tbe);
        m_rbf   = rx ? 1'b1 : ((re && a == 3'd3) ? 1'b0 : m_rbf);
        if (we && a == 3'd1) begin m_tie = d[4]; m_rie = d[5]; end
        if (we && a == 3'd5) m_en = d[0];
        if (we && a == 3'd6) m_lvl = d[2:0];
        m_pulse = n_pulse;
        m_flag  = n_flag;
        it.exp = {6'b0, m_rbf, m_tbe, 2'b0, m_rie, m_tie, 4'b0,
                  m_pulse, m_flag, m_flag & m_en, m_lvl};
        it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk);
    endtask

    // monitor: compares a quarter period after each edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (sb_q.size() > 0) begin
            item_t it;
            logic [21:0] act;
            it  = sb_q.pop_front();
            act = {status_o, ctrl_o, irq_pulse_o, flag_o, core_req_o, core_lvl_o};
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0,0,0,0,3'd0,8'h00, "R1 reset state");
        step(0,0,1,0,3'd2,8'hA5, "R2 txd write clears empty");
        step(1,0,0,0,3'd0,8'h00, "R2 R5 tx strobe sets empty, no pulse when disabled");
        step(0,1,0,0,3'd0,8'h00, "R3 R5 rx strobe sets full, no pulse");
        step(0,0,0,1,3'd3,8'h00, "R3 rxd read clears full");
        step(0,0,1,0,3'd1,8'hFF, "R4 ctrl write only bits 4 and 5");
        step(1,0,0,0,3'd0,8'h00, "R5 enabled tx strobe pulses");
        step(0,0,0,0,3'd0,8'h00, "R7 R9 flag set with channel disabled, no req");
        step(0,0,1,0,3'd5,8'h01, "R9 channel enable raises req");
        step(0,0,1,0,3'd6,8'h05, "R10 level write");
        step(0,0,1,0,3'd4,8'h01, "R8 flag clear");
        step(1,1,0,0,3'd0,8'h00, "R6 both causes single pulse");
        step(0,0,0,0,3'd0,8'h00, "R6 R7 pulse ends, flag set");
        step(0,0,1,0,3'd4,8'h01, "R8 clear");
        step(0,1,0,0,3'd0,8'h00, "R5 rx pulse");
        step(0,0,1,0,3'd4,8'h01, "R8 set wins over clear");
        step(0,0,1,0,3'd4,8'h00, "R8 clear with bit0 zero ignored");
        step(1,0,1,0,3'd2,8'h00, "R2 strobe wins over txd write");
        step(0,1,0,1,3'd3,8'h00, "R3 strobe wins over rxd read");
        step(0,0,1,0,3'd1,8'h10, "R4 only tx enable");
        step(0,1,0,0,3'd0,8'h00, "R5 rx strobe with rx enable off");
        step(0,0,1,0,3'd6,8'h0A, "R10 level from low bits");
        step(0,0,1,0,3'd5,8'h00, "R9 channel disable drops req");
        step(0,0,0,0,3'd0,8'h00, "R10 level holds");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule